// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transceiver

This block is a character-oriented serial transmitter and receiver pair that shares one set of framing controls and one baud-rate tick input. The controls set the character length (5 to 8 bits), whether a parity bit is present and its sense, the stop interval (1, 1.5 or 2 bit times), and the number of ticks per bit. The stop-interval field also acts as the enable: with that field at zero, both directions are held idle.

The transmitter accepts a parallel byte and sends a start bit, the data least significant bit first, an optional parity bit and the stop interval. It can also hold the line in a break (continuous space) on request. The receiver waits on an idle mark line for a falling edge and confirms the start bit at its centre. It then samples every later bit at mid-cell and returns right-justified data with a one-cycle strobe and error flags. The flags cover parity errors, framing errors and received breaks.

The framing controls are expected to stay stable while a character is in flight in either direction.

Top module: `async_serial_xcvr`

## Requirements
- R1: After reset the line output `txd` is 1 (mark), `tx_busy` is 0 and `rx_valid` is 0.
- R2: A transmitted frame is a 0 start bit, then `char_len`+5 data bits least significant bit first (`char_len` 00=5, 01=6, 10=7, 11=8), then the optional parity bit, then the stop interval at 1. `tx_load` is accepted only while `tx_busy` is 0, and `tx_busy` goes high on the following cycle. Each bit lasts exactly N ticks, and the start bit begins on the first tick after acceptance.
- R3: With `par_en`=1 a parity bit follows the data. With `par_odd`=1 the data plus parity hold an odd number of ones, and with `par_odd`=0 they hold an even number.
- R4: `stop_sel` 01 gives a stop interval of N ticks, 10 gives N+ceil(N/2) ticks (1.5 bits) and 11 gives 2N ticks. `tx_busy` falls exactly (1+data bits+parity bits)·N + stop ticks after the tick on which the start bit began.
- R5: `clk_fac` selects N ticks per bit: 00=1, 01=16, 10=32, 11=64. The receiver samples each bit at floor(N/2) ticks past its cell start, measured from the tick on which the falling edge is first seen.
- R6: With `stop_sel`=00 the transmitter stays idle with `txd`=1 and ignores `tx_load` and `brk_req`, and the receiver reports no characters.
- R7: A start edge is rejected, with no character reported, if the line is back at 1 at the start-bit mid-cell sample.
- R8: `rx_par_err` is 1 with the strobe when parity is enabled and the received data plus parity bit do not match the selected sense.
- R9: `rx_frm_err` is 1 with the strobe when the first stop-bit sample reads 0.
- R10: When every sample of a character, stop sample included, reads 0, the strobe carries `rx_break`=1, `rx_frm_err`=1 and data 0. The receiver then searches for no new start bit until the line has returned to 1.
- R11: `rx_valid` is a single-cycle pulse issued N−floor(N/2) ticks after the stop mid-cell sample. That is the end of the stop bit, on tick (1+data+parity+1)·N counted from the detection tick. `rx_data` is right-justified with unused upper bits 0. The data and flags hold until the next strobe.
- R12: While `brk_req`=1 and the block is enabled, `txd` is 0 from the next cycle, any character in progress is abandoned, `tx_busy` is 0 and `tx_load` is ignored. `txd` returns to 1 on the cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle tick, N per bit time |
| stop_sel | input | 2 | Stop interval select; 00 disables the block |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| clk_fac | input | 2 | Ticks per bit select |
| brk_req | input | 1 | Hold transmit line in break |
| tx_data | input | 8 | Byte to send (low bits used) |
| tx_load | input | 1 | Start sending `tx_data` |
| tx_busy | output | 1 | Transmitter sending a character |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Received data, right-justified |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_par_err | output | 1 | Parity mismatch on last character |
| rx_frm_err | output | 1 | Stop bit read as 0 on last character |
| rx_break | output | 1 | Last character was all zeros |

## Verification
The bench measures transmitted frames tick by tick, so a design that miscounted the 1.5-stop interval would drop `tx_busy` at the wrong tick. The x1 factor, where half a cell rounds to zero, gets the same measurement, as would one whose parity sense was inverted, which is caught by the sampled bit. On the receive side, a short start glitch must produce no character, and a design that skipped the mid-cell confirmation would report a spurious byte. A line held low for three frame times must give exactly one break report; a receiver that did not wait for mark would keep reporting breaks. Break generation is started partway through a character, and a design that let the character finish would show `txd` going high or `tx_busy` staying set.

// File: rtl/async_serial_xcvr.sv
module async_serial_xcvr #(
  parameter int CW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] stop_sel,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [1:0] clk_fac,
  input  logic       brk_req,
  input  logic [7:0] tx_data,
  input  logic       tx_load,
  output logic       tx_busy,
  output logic       txd,
  input  logic       rxd,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_par_err,
  output logic       rx_frm_err,
  output logic       rx_break
);

  typedef enum logic [2:0] {T_IDLE, T_ARM, T_START, T_DATA, T_PAR, T_STOP} tx_st_t;
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_FIN, R_BRKW} rx_st_t;

  logic          async_en;
  logic [CW-1:0] n_bit, n_half, n_stop;
  logic [2:0]    n_last;
  logic [7:0]    dmask;

  assign async_en = |stop_sel;
  assign n_half   = n_bit >> 1;
  assign n_last   = 3'd4 + {1'b0, char_len};
  assign dmask    = 8'hFF >> (2'd3 - char_len);

  always_comb begin
    case (clk_fac)
      2'b00:   n_bit = CW'(1);
      2'b01:   n_bit = CW'(16);
      2'b10:   n_bit = CW'(32);
      default: n_bit = CW'(64);
    endcase
    case (stop_sel)
      2'b10:   n_stop = n_bit + ((n_bit + CW'(1)) >> 1);
      2'b11:   n_stop = n_bit << 1;
      default: n_stop = n_bit;
    endcase
  end

  // transmitter
  tx_st_t        tx_st;
  logic [CW-1:0] tx_cnt;
  logic [7:0]    tx_sh;
  logic [2:0]    tx_idx;
  logic          tx_pbit, txd_q;

  assign tx_busy = (tx_st != T_IDLE);
  assign txd     = txd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st   <= T_IDLE;
      tx_cnt  <= '0;
      tx_sh   <= '0;
      tx_idx  <= '0;
      tx_pbit <= 1'b0;
      txd_q   <= 1'b1;
    end else if (!async_en || brk_req) begin
      tx_st <= T_IDLE;
      txd_q <= !async_en;
    end else begin
      case (tx_st)
        T_IDLE: begin
          txd_q <= 1'b1;
          if (tx_load) begin
            tx_sh   <= tx_data & dmask;
            tx_pbit <= (^(tx_data & dmask)) ^ par_odd;
            tx_st   <= T_ARM;
          end
        end
        T_ARM: if (baud_tick) begin
          txd_q  <= 1'b0;
          tx_cnt <= n_bit - CW'(1);
          tx_st  <= T_START;
        end
        default: if (baud_tick) begin
          if (tx_cnt != '0) tx_cnt <= tx_cnt - CW'(1);
          else begin
            tx_cnt <= n_bit - CW'(1);
            case (tx_st)
              T_START: begin
                txd_q  <= tx_sh[0];
                tx_idx <= '0;
                tx_st  <= T_DATA;
              end
              T_DATA: begin
                if (tx_idx == n_last) begin
                  if (par_en) begin
                    txd_q <= tx_pbit;
                    tx_st <= T_PAR;
                  end else begin
                    txd_q  <= 1'b1;
                    tx_cnt <= n_stop - CW'(1);
                    tx_st  <= T_STOP;
                  end
                end else begin
                  tx_sh  <= tx_sh >> 1;
                  txd_q  <= tx_sh[1];
                  tx_idx <= tx_idx + 3'd1;
                end
              end
              T_PAR: begin
                txd_q  <= 1'b1;
                tx_cnt <= n_stop - CW'(1);
                tx_st  <= T_STOP;
              end
              default: tx_st <= T_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // receiver
  rx_st_t        rx_st;
  logic [CW-1:0] rx_cnt;
  logic [7:0]    rx_sh;
  logic [2:0]    rx_idx;
  logic          rx_ones, rx_acc, rx_frm;
  logic [7:0]    rx_data_q;
  logic          rx_valid_q, rx_perr_q, rx_frm_q, rx_brk_q;

  assign rx_data    = rx_data_q;
  assign rx_valid   = rx_valid_q;
  assign rx_par_err = rx_perr_q;
  assign rx_frm_err = rx_frm_q;
  assign rx_break   = rx_brk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st      <= R_IDLE;
      rx_cnt     <= '0;
      rx_sh      <= '0;
      rx_idx     <= '0;
      rx_ones    <= 1'b0;
      rx_acc     <= 1'b0;
      rx_frm     <= 1'b0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
      rx_perr_q  <= 1'b0;
      rx_frm_q   <= 1'b0;
      rx_brk_q   <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      if (!async_en) rx_st <= R_IDLE;
      else if (baud_tick) begin
        case (rx_st)
          R_IDLE: if (!rxd) begin
            rx_sh   <= '0;
            rx_idx  <= '0;
            rx_ones <= 1'b0;
            rx_acc  <= par_odd;
            if (n_bit == CW'(1)) begin
              rx_cnt <= '0;
              rx_st  <= R_DATA;
            end else begin
              rx_cnt <= n_half - CW'(1);
              rx_st  <= R_START;
            end
          end
          R_BRKW: if (rxd) rx_st <= R_IDLE;
          default: begin
            if (rx_cnt != '0) rx_cnt <= rx_cnt - CW'(1);
            else begin
              rx_cnt <= n_bit - CW'(1);
              case (rx_st)
                R_START: rx_st <= rxd ? R_IDLE : R_DATA;
                R_DATA: begin
                  rx_sh[rx_idx] <= rxd;
                  rx_ones       <= rx_ones | rxd;
                  rx_acc        <= rx_acc ^ rxd;
                  rx_idx        <= rx_idx + 3'd1;
                  if (rx_idx == n_last) rx_st <= par_en ? R_PAR : R_STOP;
                end
                R_PAR: begin
                  rx_ones <= rx_ones | rxd;
                  rx_acc  <= rx_acc ^ rxd;
                  rx_st   <= R_STOP;
                end
                R_STOP: begin
                  rx_frm  <= !rxd;
                  rx_ones <= rx_ones | rxd;
                  rx_cnt  <= n_bit - n_half - CW'(1);
                  rx_st   <= R_FIN;
                end
                default: begin
                  rx_valid_q <= 1'b1;
                  rx_data_q  <= rx_sh;
                  rx_perr_q  <= par_en & rx_acc;
                  rx_frm_q   <= rx_frm;
                  rx_brk_q   <= !rx_ones;
                  rx_st      <= rx_ones ? R_IDLE : R_BRKW;
                end
              endcase
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/async_serial_xcvr_chk.sv
module async_serial_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] stop_sel,
  input logic [1:0] char_len,
  input logic       brk_req,
  input logic       tx_busy,
  input logic       txd,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_frm_err,
  input logic       rx_break
);

  AST_DISABLED_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_sel == 2'b00) |=> (txd && !tx_busy)); // R6

  AST_BREAK_HOLDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && stop_sel != 2'b00) |=> (!txd && !tx_busy)); // R12

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R11

  AST_BREAK_IS_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_break) |-> (rx_frm_err && rx_data == 8'h00)); // R10

  AST_SHORT_CHAR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && char_len == 2'b00) |-> (rx_data[7:5] == 3'b000)); // R11

endmodule

bind async_serial_xcvr async_serial_xcvr_chk chk_i (.*);

// File: tb/async_serial_xcvr_tb_top.sv
`timescale 1ns/1ps
module async_serial_xcvr_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        baud_tick = 1'b0;
  logic [1:0]  div = 2'd0;
  int unsigned tick_cnt = 0;
  always @(posedge clk) begin
    div       <= div + 2'd1;
    baud_tick <= (div == 2'd3);
    if (baud_tick) tick_cnt <= tick_cnt + 1;
  end

  logic [1:0] stop_sel = 2'b01, char_len = 2'b11, clk_fac = 2'b01;
  logic       par_en = 1'b0, par_odd = 1'b0, brk_req = 1'b0, tx_load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_busy, txd, rx_valid, rx_par_err, rx_frm_err, rx_break;
  logic [7:0] rx_data;
  logic       loop_en = 1'b0, rxd_drv = 1'b1, rxd;
  assign rxd = loop_en ? txd : rxd_drv;

  async_serial_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .stop_sel(stop_sel),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .clk_fac(clk_fac),
    .brk_req(brk_req), .tx_data(tx_data), .tx_load(tx_load), .tx_busy(tx_busy),
    .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_break(rx_break));

  int checks = 0, failures = 0;
  bit done = 1'b0;

  int          cap_cnt = 0, vld_run = 0, vld_max = 0;
  logic [7:0]  cap_data = 8'h00;
  bit          cap_perr, cap_frm, cap_brk;
  int unsigned cap_tick = 0;
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      cap_cnt++;
      cap_data = rx_data;
      cap_perr = rx_par_err;
      cap_frm  = rx_frm_err;
      cap_brk  = rx_break;
      cap_tick = tick_cnt;
      vld_run++;
      if (vld_run > vld_max) vld_max = vld_run;
    end else vld_run = 0;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nticks(input logic [1:0] f);
    case (f)
      2'b00: return 1;
      2'b01: return 16;
      2'b10: return 32;
      default: return 64;
    endcase
  endfunction

  function automatic int stop_ticks(input logic [1:0] s, input int n);
    if (s == 2'b10) return n + (n + 1) / 2;
    if (s == 2'b11) return 2 * n;
    return n;
  endfunction

  task automatic wait_until(input int unsigned t);
    while (tick_cnt < t) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] s, input int len, input bit pe,
                         input bit po, input logic [1:0] f);
    @(negedge clk);
    stop_sel = s; char_len = 2'(len - 5); par_en = pe; par_odd = po; clk_fac = f;
    @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input int len, input bit pe, input bit pb,
                         input bit sv, input int n, output int unsigned t0);
    logic [11:0] bits;
    int nb;
    bits = '0;
    nb = len + (pe ? 1 : 0) + 2;
    for (int i = 0; i < len; i++) bits[1+i] = d[i];
    if (pe) bits[1+len] = pb;
    bits[nb-1] = sv;
    @(negedge clk);
    t0 = tick_cnt;
    for (int k = 0; k < nb; k++) begin
      rxd_drv = bits[k];
      wait_until(t0 + (k + 1) * n);
    end
    rxd_drv = 1'b1;
    wait_until(t0 + nb * n + 3);
  endtask

  // R2 R3 R4 R5: sampled transmit waveform and frame length
  task automatic tx_wave(input int len, input bit pe, input bit po,
                         input logic [1:0] s, input logic [1:0] f, input logic [7:0] d);
    int n, nb, rel, guard;
    int unsigned f0;
    logic [11:0] seen, expv;
    logic [7:0] md;
    n = nticks(f);
    loop_en = 1'b0;
    set_cfg(s, len, pe, po, f);
    md = d & (8'hFF >> (8 - len));
    nb = 1 + len + (pe ? 1 : 0);
    expv = '0;
    for (int i = 0; i < len; i++) expv[1+i] = md[i];
    if (pe) expv[1+len] = po ? ~($countones(md) % 2 == 1) : ($countones(md) % 2 == 1);
    expv[nb] = 1'b1;
    seen = '1;
    tx_data = d; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    chk("R2 busy after load", tx_busy, 1);
    guard = 0;
    while (txd && guard < 1000) begin @(negedge clk); guard++; end
    f0 = tick_cnt;
    guard = 0;
    do begin
      rel = int'(tick_cnt - f0);
      if (rel <= nb * n + n / 2 && rel % n == n / 2) seen[rel / n] = txd;
      @(negedge clk);
      guard++;
    end while (tx_busy && guard < 40000);
    for (int b = 0; b <= nb; b++)
      chk((b == 1 + len && pe) ? "R3 parity bit" : "R2 frame bit", seen[b], expv[b]);
    chk("R4 frame ticks", int'(tick_cnt - f0), nb * n + stop_ticks(s, n));
    chk("R1 idle mark after frame", txd, 1);
  endtask

  // R2 R11: loopback through the receiver
  task automatic loopback(input int len, input bit pe, input bit po,
                          input logic [1:0] s, input logic [1:0] f, input logic [7:0] d);
    int c0, guard;
    loop_en = 1'b1;
    set_cfg(s, len, pe, po, f);
    c0 = cap_cnt;
    tx_data = d; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    guard = 0;
    while (cap_cnt == c0 && guard < 20000) begin @(negedge clk); guard++; end
    chk("R11 one char received", cap_cnt - c0, 1);
    chk("R11 right-justified data", cap_data, d & (8'hFF >> (8 - len)));
    chk("R8 no parity error", cap_perr, 0);
    chk("R9 no framing error", cap_frm, 0);
    while (tx_busy) @(negedge clk);
    wait_until(tick_cnt + 4);
    loop_en = 1'b0;
  endtask

  task automatic t_rx_timing();
    int unsigned t0;
    int c0;
    set_cfg(2'b01, 8, 1'b0, 1'b0, 2'b01);
    c0 = cap_cnt;
    send_rx(8'h3C, 8, 1'b0, 1'b0, 1'b1, 16, t0);
    chk("R11 strobe count", cap_cnt - c0, 1);
    chk("R11 strobe at stop end", int'(cap_tick), int'(t0 + 1 + 10 * 16));
    chk("R5 mid-cell data", cap_data, 8'h3C);
  endtask

  task automatic t_rx_parity();
    int unsigned t0;
    set_cfg(2'b01, 8, 1'b1, 1'b0, 2'b10);
    send_rx(8'h01, 8, 1'b1, 1'b1, 1'b1, 32, t0);
    chk("R8 good even parity", cap_perr, 0);
    send_rx(8'h01, 8, 1'b1, 1'b0, 1'b1, 32, t0);
    chk("R8 bad even parity", cap_perr, 1);
    chk("R8 no framing error", cap_frm, 0);
    set_cfg(2'b01, 6, 1'b1, 1'b1, 2'b01);
    send_rx(8'h03, 6, 1'b1, 1'b0, 1'b1, 16, t0);
    chk("R8 bad odd parity", cap_perr, 1);
  endtask

  task automatic t_rx_framing();
    int unsigned t0;
    set_cfg(2'b01, 8, 1'b0, 1'b0, 2'b01);
    send_rx(8'h81, 8, 1'b0, 1'b0, 1'b0, 16, t0);
    chk("R9 framing flagged", cap_frm, 1);
    chk("R9 not a break", cap_brk, 0);
    chk("R9 data kept", cap_data, 8'h81);
  endtask

  task automatic t_rx_break();
    int unsigned t0;
    int c0;
    set_cfg(2'b01, 8, 1'b0, 1'b0, 2'b01);
    c0 = cap_cnt;
    @(negedge clk);
    t0 = tick_cnt;
    rxd_drv = 1'b0;
    wait_until(t0 + 3 * 10 * 16);
    rxd_drv = 1'b1;
    wait_until(tick_cnt + 8);
    chk("R10 single break report", cap_cnt - c0, 1);
    chk("R10 break flag", cap_brk, 1);
    chk("R10 framing with break", cap_frm, 1);
    chk("R10 zero data", cap_data, 0);
    send_rx(8'h5E, 8, 1'b0, 1'b0, 1'b1, 16, t0);
    chk("R10 resumes after mark", cap_data, 8'h5E);
    chk("R10 flag cleared", cap_brk, 0);
  endtask

  task automatic t_false_start();
    int unsigned t0;
    int c0;
    set_cfg(2'b01, 8, 1'b0, 1'b0, 2'b01);
    c0 = cap_cnt;
    @(negedge clk);
    t0 = tick_cnt;
    rxd_drv = 1'b0;
    wait_until(t0 + 4);
    rxd_drv = 1'b1;
    wait_until(t0 + 200);
    chk("R7 glitch rejected", cap_cnt - c0, 0);
    send_rx(8'hC6, 8, 1'b0, 1'b0, 1'b1, 16, t0);
    chk("R7 next char clean", cap_data, 8'hC6);
  endtask

  task automatic t_disabled();
    int unsigned t0;
    int c0;
    set_cfg(2'b00, 8, 1'b0, 1'b0, 2'b01);
    c0 = cap_cnt;
    brk_req = 1'b1;
    tx_data = 8'h00; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    @(negedge clk);
    chk("R6 load ignored", tx_busy, 0);
    chk("R6 break ignored", txd, 1);
    brk_req = 1'b0;
    send_rx(8'h00, 8, 1'b0, 1'b0, 1'b1, 16, t0);
    chk("R6 receiver silent", cap_cnt - c0, 0);
    chk("R6 line mark", txd, 1);
  endtask

  task automatic t_break_gen();
    loop_en = 1'b0;
    set_cfg(2'b01, 8, 1'b0, 1'b0, 2'b01);
    tx_data = 8'hFF; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    wait_until(tick_cnt + 40);
    chk("R12 mid-char line high", txd, 1);
    brk_req = 1'b1;
    @(negedge clk);
    chk("R12 break drives space", txd, 0);
    chk("R12 char abandoned", tx_busy, 0);
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    wait_until(tick_cnt + 200);
    chk("R12 load ignored in break", tx_busy, 0);
    chk("R12 break held", txd, 0);
    brk_req = 1'b0;
    @(negedge clk);
    chk("R12 mark after release", txd, 1);
    wait_until(tick_cnt + 20);
    chk("R12 stays idle", tx_busy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 reset txd", txd, 1);
    chk("R1 reset busy", tx_busy, 0);
    chk("R1 reset valid", rx_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tx_wave(8, 1'b0, 1'b0, 2'b01, 2'b01, 8'h5A);
    tx_wave(7, 1'b1, 1'b1, 2'b10, 2'b01, 8'h03);
    tx_wave(5, 1'b1, 1'b0, 2'b11, 2'b00, 8'h16);
    tx_wave(6, 1'b0, 1'b0, 2'b10, 2'b00, 8'h2D);
    tx_wave(8, 1'b1, 1'b0, 2'b01, 2'b11, 8'hC3);
    tx_wave(6, 1'b1, 1'b1, 2'b11, 2'b10, 8'h15);
    loopback(8, 1'b0, 1'b0, 2'b01, 2'b01, 8'hA5);
    loopback(5, 1'b1, 1'b0, 2'b10, 2'b00, 8'hFF);
    loopback(7, 1'b1, 1'b1, 2'b11, 2'b10, 8'h6E);
    loopback(6, 1'b1, 1'b1, 2'b01, 2'b11, 8'hFF);
    t_rx_timing();
    t_rx_parity();
    t_rx_framing();
    t_rx_break();
    t_false_start();
    t_disabled();
    t_break_gen();
    chk("R11 strobe width", vld_max, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule